// File: doc/BRIEF.md
# E1 Transmit Frame and Multiframe Formatter

This block assembles the outgoing 2.048 Mb/s E1 bit stream, one bit per clock. It keeps its own position in the 16-frame channel-associated-signalling multiframe (bit within timeslot, timeslot within frame, frame within multiframe). Into timeslot 0 it writes the frame alignment word on alignment frames, and the alarm and national bits on the other frames. Into timeslot 16 it writes the multiframe alignment nibble and spare bits on multiframe frame 0, and per-channel signalling bits on frames 1 to 15. All other timeslots carry the payload bit from the serial input unchanged.

Three strobes mark timeslot 16, multiframe frame 0 and alignment frames, so that neighbouring logic can line up its payload and signalling data. A one-clock sync pulse moves the counters to the start of frame 0. With the sync input held low, the counters run freely. A phase control chooses whether multiframe frame 0 is an alignment frame or a non-alignment frame. A force control fills timeslot 16 with ones in every frame. CRC-4 and line coding are left to other blocks.

Top module: `e1_tx_formatter`

## Requirements
- R1: While reset is asserted and right after it is released, `tx_out` is 1. The position is frame 0, timeslot 0, bit 0: `mf0_stb` is 1, `ts16_stb` is 0, and `align_stb` equals the inverse of `mf_phase`.
- R2: Each rising clock edge advances the position by one bit. Timeslots have 8 bits, frames have 32 timeslots and the multiframe has 16 frames. `ts16_stb` is high for exactly the 8 bits of timeslot 16 of every frame. `mf0_stb` is high for the 256 bits of frame 0.
- R3: With `mf_phase`=0 the even frames (0,2,..,14) are alignment frames. With `mf_phase`=1 the odd frames are alignment frames. `align_stb` is high during alignment frames. In timeslot 0 of an alignment frame, bits 2 to 8 (transmit order, first bit of the timeslot is bit 1) are 0,0,1,1,0,1,1.
- R4: In timeslot 0 of a non-alignment frame, bit 2 is 1 and bit 3 is `remote_alarm`. Bits 4 to 8 are `nat_bits[4]` down to `nat_bits[0]`.
- R5: Bit 1 of timeslot 0 is `intl_bit` in every frame.
- R6: In timeslot 16 of frame 0, bits 1 to 4 are 0 and bits 5 to 8 are `mf_spare[3]` down to `mf_spare[0]`.
- R7: In timeslot 16 of frames 1 to 15, each bit is taken from `sig_in` when `sig_src_sel`=1 and from `ser_in` when it is 0.
- R8: When `ts16_ones`=1, every bit of timeslot 16 is 1 in all 16 frames. This override takes precedence over R6 and R7.
- R9: Inputs are sampled on the falling clock edge, and `tx_out` changes on the rising edge. A bit presented on `ser_in` during one bit period goes out in the next bit period, and the same holds for `sig_in`. In timeslots other than 0 and 16, `tx_out` equals `ser_in` from the previous bit.
- R10: When `mf_sync_in` is sampled high, the next bit period is frame 0, timeslot 0, bit 1. When `mf_sync_in` is held low, the counters wrap freely from frame 15 to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; inputs sampled on falling edge, outputs on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Payload serial bit (also timeslot 16 source when sig_src_sel=0) |
| sig_in | input | 1 | Separate signalling bit for timeslot 16 |
| mf_sync_in | input | 1 | Multiframe sync pulse; low lets counters free-run |
| sig_src_sel | input | 1 | 1 = timeslot 16 from sig_in, 0 = from ser_in |
| ts16_ones | input | 1 | Force timeslot 16 to all ones |
| mf_phase | input | 1 | 0 = frame 0 is an alignment frame, 1 = non-alignment frame |
| intl_bit | input | 1 | Bit 1 of timeslot 0 |
| remote_alarm | input | 1 | Bit 3 of timeslot 0 in non-alignment frames |
| nat_bits | input | 5 | Bits 4..8 of timeslot 0 in non-alignment frames |
| mf_spare | input | 4 | Bits 5..8 of timeslot 16 in frame 0 |
| tx_out | output | 1 | Formatted NRZ output stream |
| ts16_stb | output | 1 | High during timeslot 16 |
| mf0_stb | output | 1 | High during multiframe frame 0 |
| align_stb | output | 1 | High during alignment frames |

## Verification
The payload and the signalling input each carry an independent pseudo-random stream. A swap of the timeslot 16 source, a missing delay or a stuck bit therefore shows up as a miscompare within a few bits. Full multiframes run with both phase settings and both signalling sources, with distinct patterns on the alarm, national and spare inputs, which separates bit-order and field-position errors. A forced-ones run shows whether the override wins in frame 0. A sync pulse placed partway through a multiframe, followed by a long free run, tells a correct restart and wrap from a counter that only resets at its natural end.

// File: rtl/e1_tx_formatter.sv
module e1_tx_formatter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       sig_in,
  input  logic       mf_sync_in,
  input  logic       sig_src_sel,
  input  logic       ts16_ones,
  input  logic       mf_phase,
  input  logic       intl_bit,
  input  logic       remote_alarm,
  input  logic [4:0] nat_bits,
  input  logic [3:0] mf_spare,
  output logic       tx_out,
  output logic       ts16_stb,
  output logic       mf0_stb,
  output logic       align_stb
);
  localparam int BIT_W = 3;
  localparam int TS_W  = 5;
  localparam int FR_W  = 4;
  localparam logic [TS_W-1:0] TS_SIG = TS_W'(16);
  localparam logic [7:0] FAW = 8'b0001_1011;

  logic [BIT_W-1:0] bit_q, bit_n;
  logic [TS_W-1:0]  ts_q, ts_n;
  logic [FR_W-1:0]  fr_q, fr_n;
  logic ser_s, sig_s, sync_s;
  logic nxt_align, fmt;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      ser_s  <= 1'b0;
      sig_s  <= 1'b0;
      sync_s <= 1'b0;
    end else begin
      ser_s  <= ser_in;
      sig_s  <= sig_in;
      sync_s <= mf_sync_in;
    end

  always_comb begin
    bit_n = bit_q + 1'b1;
    ts_n  = ts_q;
    fr_n  = fr_q;
    if (&bit_q) begin
      ts_n = ts_q + 1'b1;
      if (&ts_q) fr_n = fr_q + 1'b1;
    end
    if (sync_s) begin
      bit_n = '0;
      ts_n  = '0;
      fr_n  = '0;
    end
  end

  assign nxt_align = ~fr_n[0] ^ mf_phase;

  always_comb begin
    fmt = ser_s;
    if (ts_n == '0) begin
      if (bit_n == '0)   fmt = intl_bit;
      else if (nxt_align) fmt = FAW[3'd7 - bit_n];
      else if (bit_n == 3'd1) fmt = 1'b1;
      else if (bit_n == 3'd2) fmt = remote_alarm;
      else               fmt = nat_bits[3'd7 - bit_n];
    end else if (ts_n == TS_SIG) begin
      if (ts16_ones)       fmt = 1'b1;
      else if (fr_n == '0) fmt = bit_n[2] ? mf_spare[2'(3'd7 - bit_n)] : 1'b0;
      else                 fmt = sig_src_sel ? sig_s : ser_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_q  <= '0;
      ts_q   <= '0;
      fr_q   <= '0;
      tx_out <= 1'b1;
    end else begin
      bit_q  <= bit_n;
      ts_q   <= ts_n;
      fr_q   <= fr_n;
      tx_out <= fmt;
    end

  assign ts16_stb  = (ts_q == TS_SIG);
  assign mf0_stb   = (fr_q == '0);
  assign align_stb = ~fr_q[0] ^ mf_phase;
endmodule

// File: rtl/e1_tx_formatter_chk.sv
module e1_tx_formatter_chk (
  input logic clk,
  input logic rst_n,
  input logic mf_sync_in,
  input logic ts16_ones,
  input logic mf_phase,
  input logic tx_out,
  input logic ts16_stb,
  input logic mf0_stb,
  input logic align_stb
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        run_q <= '0;
    else if (ts16_stb) run_q <= run_q + 1'b1;
    else               run_q <= '0;

  p_ts16_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ts16_stb) && !$past(mf_sync_in) |-> run_q == 4'd8);

  p_sync_frame0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mf_sync_in |=> mf0_stb && !ts16_stb);

  p_ts16_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ts16_stb && $past(ts16_ones) |-> tx_out);

  p_frame0_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mf0_stb |-> align_stb != mf_phase);

  p_align_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ts16_stb && $past(ts16_stb) && $stable(mf_phase) |-> $stable(align_stb));
endmodule

bind e1_tx_formatter e1_tx_formatter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mf_sync_in(mf_sync_in), .ts16_ones(ts16_ones),
  .mf_phase(mf_phase), .tx_out(tx_out), .ts16_stb(ts16_stb),
  .mf0_stb(mf0_stb), .align_stb(align_stb)
);

// File: tb/e1_tx_formatter_tb_top.sv
module e1_tx_formatter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0, sig_in = 1'b0, mf_sync_in = 1'b0;
  logic sig_src_sel = 1'b0, ts16_ones = 1'b0, mf_phase = 1'b0;
  logic intl_bit = 1'b1, remote_alarm = 1'b0;
  logic [4:0] nat_bits = 5'b10110;
  logic [3:0] mf_spare = 4'b1011;
  logic tx_out, ts16_stb, mf0_stb, align_stb;

  int vectors = 0, errors = 0;
  bit done = 0;
  int m_fr = 0, m_ts = 0, m_bit = 0;
  bit p_ser, p_sig, p_sync;

  always #5 clk = ~clk;

  e1_tx_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sig_in(sig_in),
    .mf_sync_in(mf_sync_in), .sig_src_sel(sig_src_sel), .ts16_ones(ts16_ones),
    .mf_phase(mf_phase), .intl_bit(intl_bit), .remote_alarm(remote_alarm),
    .nat_bits(nat_bits), .mf_spare(mf_spare), .tx_out(tx_out),
    .ts16_stb(ts16_stb), .mf0_stb(mf0_stb), .align_stb(align_stb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fr=%0d ts=%0d bit=%0d actual=%b expected=%b",
               req, m_fr, m_ts, m_bit + 1, act, exp);
    end
  endtask

  function automatic bit want_bit();
    bit alig = ((m_fr % 2) == 0) ^ mf_phase;
    bit [6:0] faw = 7'b0011011;
    if (m_ts == 0) begin
      if (m_bit == 0) return intl_bit;
      if (alig) return faw[7 - m_bit];
      if (m_bit == 1) return 1'b1;
      if (m_bit == 2) return remote_alarm;
      return nat_bits[7 - m_bit];
    end
    if (m_ts == 16) begin
      if (ts16_ones) return 1'b1;
      if (m_fr == 0) return (m_bit < 4) ? 1'b0 : mf_spare[7 - m_bit];
      return sig_src_sel ? p_sig : p_ser;
    end
    return p_ser;
  endfunction

  function automatic string which_req();
    if (m_ts == 0) begin
      if (m_bit == 0) return "R5";
      return ((((m_fr % 2) == 0) ^ mf_phase) ? "R3" : "R4");
    end
    if (m_ts == 16) begin
      if (ts16_ones) return "R8";
      return (m_fr == 0) ? "R6" : "R7";
    end
    return "R9";
  endfunction

  task automatic step(input bit nsync);
    p_ser = ser_in; p_sig = sig_in; p_sync = mf_sync_in;
    @(posedge clk); #1;
    if (p_sync) begin
      m_fr = 0; m_ts = 0; m_bit = 0;
    end else begin
      m_bit++;
      if (m_bit == 8) begin m_bit = 0; m_ts++; end
      if (m_ts == 32) begin m_ts = 0; m_fr = (m_fr + 1) % 16; end
    end
    chk(which_req(), tx_out, want_bit());
    chk("R2", ts16_stb, m_ts == 16);
    chk(p_sync ? "R10" : "R2", mf0_stb, m_fr == 0);
    chk("R3", align_stb, ((m_fr % 2) == 0) ^ mf_phase);
    ser_in = 1'($urandom_range(0, 1));
    sig_in = 1'($urandom_range(0, 1));
    mf_sync_in = nsync;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", tx_out, 1'b1);
    chk("R1", mf0_stb, 1'b1);
    chk("R1", ts16_stb, 1'b0);
    chk("R1", align_stb, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4200; i++) step(0);
    sig_src_sel = 1'b1; intl_bit = 1'b0; nat_bits = 5'b01001; mf_spare = 4'b0110;
    for (int i = 0; i < 4200; i++) step(0);
    mf_phase = 1'b1; remote_alarm = 1'b1; nat_bits = 5'b11100;
    for (int i = 0; i < 4200; i++) step(0);
    ts16_ones = 1'b1;
    for (int i = 0; i < 4200; i++) step(0);
    ts16_ones = 1'b0; sig_src_sel = 1'b0;
    for (int i = 0; i < 1234; i++) step(0);
    step(1);
    for (int i = 0; i < 2000; i++) step(0);
    mf_phase = 1'b0;
    for (int i = 0; i < 777; i++) step(0);
    step(1);
    for (int i = 0; i < 8200; i++) step(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule